// File: doc/BRIEF.md
# Green-Mode Hopping PWM Timebase

This block is the digital timebase of a flyback PWM controller. It takes an unsigned feedback code from an ADC and decides how long each switching period lasts, where in the period the maximum-duty limit falls, and whether the period carries a pulse at all. At heavy load the period is fixed at the normal rate. As the feedback falls into the green band, the period grows in a straight line with the feedback (off-time modulation) until it reaches the green minimum frequency. Below that band the period stays at the green minimum.

To spread conducted EMI, a triangular dither adds a small signed offset to every period. The depth of that offset and the number of periods between dither steps are both interpolated between a normal-mode setting and a green-mode setting. When feedback falls very low the block enters zero-duty burst. It leaves burst only when feedback climbs past a higher threshold. While in burst the timebase keeps counting and dithering but emits no pulses.

All new settings are taken only at the boundary between periods, so a running period is never shortened or stretched. The defaults (feedback codes 144/112/104/96, periods of 100 and 295 clocks) model a 65 kHz to 22 kHz range on an 8-bit feedback scale.

Top module: `gm_hop_timebase`

## Requirements
- R1: While rst_ni is low, cyc_start_o, duty_end_o and burst_skip_o are all low. The first period starts with cyc_start_o high in the first clock after rst_ni rises, and its dither offset is zero.
- R2: Any feedback code at or above FB_NORM (144) gives a base period of PER_NORM (100 clocks). A code of 255 behaves exactly like 144.
- R3: For FB_GREEN < fb < FB_NORM the base period is PER_NORM + floor((PER_GREEN-PER_NORM)*(FB_NORM-fb)/(FB_NORM-FB_GREEN)). For any fb at or below FB_GREEN (112) it is PER_GREEN (295).
- R4: A dither value u starts at 0 rising and moves by one per step within -4..+4 (2^HOP_SHIFT), turning at the ends. It is updated before the new period is formed, and the period is base + floor(u*depth/4). At fb >= 144 the first 20 periods are 100,101,101,103,103,104,104,106,106,104,104,103,103,101,101,100,100,98,98,97.
- R5: The dither depth runs from DEPTH_NORM (6) to DEPTH_GREEN (19), and the periods-per-step divider from DIV_NORM (2) to DIV_GREEN (5). Both use the same interpolation as R3. A step happens at a boundary when the count of boundaries since the last step, including this one, reaches the divider.
- R6: duty_end_o is high for one clock at floor(period*114/128) clocks after cyc_start_o, marking the roughly 89 % maximum duty.
- R7: At a boundary, fb < FB_STOP (96) sets burst. fb > FB_RESUME (104) clears it. Codes from 96 to 104 inclusive hold the previous state. While in burst, cyc_start_o and duty_end_o stay low and burst_skip_o is high. When burst clears, cyc_start_o rises in the same clock.
- R8: A feedback change in the middle of a period does not change that period's length or duty point. It takes effect from the next period.
- R9: cyc_start_o and duty_end_o are never high in the same clock, and cyc_start_o is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fb_code_i | input | FB_W (8) | Unsigned digitized feedback voltage |
| cyc_start_o | output | 1 | One-clock pulse at the start of each pulsed period (gate set) |
| duty_end_o | output | 1 | One-clock pulse at the maximum-duty point (forced gate off) |
| burst_skip_o | output | 1 | High while zero-duty burst suppresses pulses |

## Verification
Steady codes at and above the normal level, inside the green slope and on the green floor are each held from reset. This separates clamping, the interpolation and the flat floor, and measures both the period and the duty point exactly. Long runs at the normal and green extremes trace the dither shape step by step. Those runs tell a wrong turn-around, a wrong depth or a wrong divider apart from a wrong base period. Codes held inside the burst hysteresis band, then just outside it on each side, check that entry and exit use different levels. A change in mid-period checks that the running period is left intact. Random feedback changes at arbitrary clocks are then compared clock by clock against a model built from the requirements.

// File: rtl/gmh_pkg.sv
`timescale 1ns/1ps
package gmh_pkg;
    // direction of the triangular dither
    typedef enum logic {
        HOP_RISE = 1'b0,
        HOP_FALL = 1'b1
    } hop_dir_e;

    // fractional bits of the maximum-duty ratio
    localparam int DUTY_FRAC_W = 7;
endpackage

// File: rtl/gmh_rate_map.sv
`timescale 1ns/1ps
// Maps the feedback code and the next dither value to the next period,
// its maximum-duty point and the dither step divider.
module gmh_rate_map #(
    parameter int FB_W        = 8,
    parameter int CNT_W       = 9,
    parameter int HOP_W       = 4,
    parameter int DIV_W       = 3,
    parameter int FB_NORM     = 144,
    parameter int FB_GREEN    = 112,
    parameter int PER_NORM    = 100,
    parameter int PER_GREEN   = 295,
    parameter int DEPTH_NORM  = 6,
    parameter int DEPTH_GREEN = 19,
    parameter int DIV_NORM    = 2,
    parameter int DIV_GREEN   = 5,
    parameter int HOP_SHIFT   = 2,
    parameter int DUTY_NUM    = 114
) (
    input  logic [FB_W-1:0]         fb_i,
    input  logic signed [HOP_W-1:0] hop_i,
    output logic [CNT_W-1:0]        period_o,
    output logic [CNT_W-1:0]        duty_o,
    output logic [DIV_W-1:0]        div_o
);
    import gmh_pkg::*;

    localparam int GSPAN = FB_NORM - FB_GREEN;

    always_comb begin
        int fb_v;
        int g_v;
        int base_v;
        int depth_v;
        int div_v;
        int off_v;
        int per_v;
        int duty_v;

        fb_v = int'(fb_i);
        if (fb_v > FB_NORM) begin
            fb_v = FB_NORM;
        end
        // green interpolation position, 0 = normal, GSPAN = green floor
        if (fb_v <= FB_GREEN) begin
            g_v = GSPAN;
        end else begin
            g_v = FB_NORM - fb_v;
        end
        base_v  = PER_NORM   + ((PER_GREEN   - PER_NORM)   * g_v) / GSPAN;
        depth_v = DEPTH_NORM + ((DEPTH_GREEN - DEPTH_NORM) * g_v) / GSPAN;
        div_v   = DIV_NORM   + ((DIV_GREEN   - DIV_NORM)   * g_v) / GSPAN;
        off_v   = (int'(hop_i) * depth_v) >>> HOP_SHIFT;
        per_v   = base_v + off_v;
        duty_v  = (per_v * DUTY_NUM) >>> DUTY_FRAC_W;

        period_o = CNT_W'(per_v);
        duty_o   = CNT_W'(duty_v);
        div_o    = DIV_W'(div_v);
    end
endmodule

// File: rtl/gmh_tri_dither.sv
`timescale 1ns/1ps
// Triangular up/down dither counter advanced once every div_i boundaries.
module gmh_tri_dither #(
    parameter int HOP_SHIFT = 2,
    parameter int HOP_W     = 4,
    parameter int DIV_W     = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tick_i,
    input  logic [DIV_W-1:0]        div_i,
    output logic signed [HOP_W-1:0] hop_nxt_o
);
    import gmh_pkg::*;

    localparam int HOP_AMP = 1 << HOP_SHIFT;

    typedef struct packed {
        logic [HOP_W-1:0] hop;
        hop_dir_e         dir;
        logic [DIV_W-1:0] hd;
    } dith_t;

    dith_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if ((st_q.hd + DIV_W'(1)) >= div_i) begin
                st_d.hd = '0;
                if (st_q.dir == HOP_RISE) begin
                    if (st_q.hop == HOP_W'(HOP_AMP)) begin
                        st_d.hop = st_q.hop - HOP_W'(1);
                        st_d.dir = HOP_FALL;
                    end else begin
                        st_d.hop = st_q.hop + HOP_W'(1);
                    end
                end else begin
                    if (st_q.hop == HOP_W'(-HOP_AMP)) begin
                        st_d.hop = st_q.hop + HOP_W'(1);
                        st_d.dir = HOP_RISE;
                    end else begin
                        st_d.hop = st_q.hop - HOP_W'(1);
                    end
                end
            end else begin
                st_d.hd = st_q.hd + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{hop: '0, dir: HOP_RISE, hd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hop_nxt_o = $signed(st_d.hop);

    assert_hop_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($signed(st_q.hop) <= HOP_AMP) && ($signed(st_q.hop) >= -HOP_AMP))
        else $error("dither value out of range");

    assert_hop_unit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.hop == $past(st_q.hop)) ||
                  (st_q.hop == $past(st_q.hop) + HOP_W'(1)) ||
                  (st_q.hop == $past(st_q.hop) - HOP_W'(1))))
        else $error("dither moved by more than one");

    assert_hop_only_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(st_q.hop))
        else $error("dither moved away from a boundary");
endmodule

// File: rtl/gmh_burst_gate.sv
`timescale 1ns/1ps
// Zero-duty burst state with separate entry and exit levels.
module gmh_burst_gate #(
    parameter int FB_W      = 8,
    parameter int FB_STOP   = 96,
    parameter int FB_RESUME = 104
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic [FB_W-1:0] fb_i,
    output logic            skip_q_o,
    output logic            skip_nxt_o
);
    typedef struct packed {
        logic skip;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (fb_i < FB_W'(FB_STOP)) begin
                st_d.skip = 1'b1;
            end else if (fb_i > FB_W'(FB_RESUME)) begin
                st_d.skip = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{skip: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_q_o   = st_q.skip;
    assign skip_nxt_o = st_d.skip;

    assert_band_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fb_i >= FB_W'(FB_STOP) && fb_i <= FB_W'(FB_RESUME)) |=> $stable(st_q.skip))
        else $error("burst state changed inside the hysteresis band");

    assert_low_enters_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && fb_i < FB_W'(FB_STOP)) |=> st_q.skip)
        else $error("burst not entered below the stop level");
endmodule

// File: rtl/gm_hop_timebase.sv
`timescale 1ns/1ps
// Green-mode hopping PWM timebase: period counter, boundary update and pulses.
module gm_hop_timebase #(
    parameter int FB_W        = 8,
    parameter int FB_NORM     = 144,
    parameter int FB_GREEN    = 112,
    parameter int FB_STOP     = 96,
    parameter int FB_RESUME   = 104,
    parameter int PER_NORM    = 100,
    parameter int PER_GREEN   = 295,
    parameter int DEPTH_NORM  = 6,
    parameter int DEPTH_GREEN = 19,
    parameter int DIV_NORM    = 2,
    parameter int DIV_GREEN   = 5,
    parameter int HOP_SHIFT   = 2,
    parameter int DUTY_NUM    = 114
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [FB_W-1:0] fb_code_i,
    output logic            cyc_start_o,
    output logic            duty_end_o,
    output logic            burst_skip_o
);
    import gmh_pkg::*;

    localparam int PER_TOP = (PER_GREEN > PER_NORM) ? PER_GREEN : PER_NORM;
    localparam int DEP_TOP = (DEPTH_GREEN > DEPTH_NORM) ? DEPTH_GREEN : DEPTH_NORM;
    localparam int PER_MAX = PER_TOP + DEP_TOP;
    localparam int CNT_W   = $clog2(PER_MAX + 1);
    localparam int DIV_TOP = (DIV_GREEN > DIV_NORM) ? DIV_GREEN : DIV_NORM;
    localparam int DIV_W   = $clog2(DIV_TOP + 1);
    localparam int HOP_W   = HOP_SHIFT + 2;
    localparam int DUTY_RST = (PER_NORM * DUTY_NUM) >> DUTY_FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             start;
        logic             dend;
    } tbase_t;

    tbase_t st_d, st_q;

    logic                    tick;
    logic signed [HOP_W-1:0] hop_nxt;
    logic [CNT_W-1:0]        per_new;
    logic [CNT_W-1:0]        duty_new;
    logic [DIV_W-1:0]        div_new;
    logic                    skip_q;
    logic                    skip_nxt;

    assign tick = (st_q.cnt == st_q.per - CNT_W'(1));

    gmh_tri_dither #(
        .HOP_SHIFT (HOP_SHIFT),
        .HOP_W     (HOP_W),
        .DIV_W     (DIV_W)
    ) u_dither (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .div_i     (div_new),
        .hop_nxt_o (hop_nxt)
    );

    gmh_rate_map #(
        .FB_W        (FB_W),
        .CNT_W       (CNT_W),
        .HOP_W       (HOP_W),
        .DIV_W       (DIV_W),
        .FB_NORM     (FB_NORM),
        .FB_GREEN    (FB_GREEN),
        .PER_NORM    (PER_NORM),
        .PER_GREEN   (PER_GREEN),
        .DEPTH_NORM  (DEPTH_NORM),
        .DEPTH_GREEN (DEPTH_GREEN),
        .DIV_NORM    (DIV_NORM),
        .DIV_GREEN   (DIV_GREEN),
        .HOP_SHIFT   (HOP_SHIFT),
        .DUTY_NUM    (DUTY_NUM)
    ) u_map (
        .fb_i     (fb_code_i),
        .hop_i    (hop_nxt),
        .period_o (per_new),
        .duty_o   (duty_new),
        .div_o    (div_new)
    );

    gmh_burst_gate #(
        .FB_W      (FB_W),
        .FB_STOP   (FB_STOP),
        .FB_RESUME (FB_RESUME)
    ) u_burst (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .fb_i       (fb_code_i),
        .skip_q_o   (skip_q),
        .skip_nxt_o (skip_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.dend  = 1'b0;
        if (tick) begin
            st_d.cnt   = '0;
            st_d.per   = per_new;
            st_d.duty  = duty_new;
            st_d.start = !skip_nxt;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.dend = (st_d.cnt == st_q.duty) && !skip_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{cnt:   CNT_W'(PER_NORM - 1),
                      per:   CNT_W'(PER_NORM),
                      duty:  CNT_W'(DUTY_RST),
                      start: 1'b0,
                      dend:  1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_start_o  = st_q.start;
    assign duty_end_o   = st_q.dend;
    assign burst_skip_o = skip_q;

    assert_count_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.per)
        else $error("period counter beyond period");

    assert_duty_inside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.duty != '0) && (st_q.duty < st_q.per))
        else $error("duty point outside period");

    assert_period_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> ($stable(st_q.per) && $stable(st_q.duty)))
        else $error("period changed mid-cycle");

    assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.start && st_q.dend))
        else $error("start and duty end together");

    assert_single_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.start |=> !st_q.start)
        else $error("start pulse wider than one clock");

    assert_quiet_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        skip_q |-> (!st_q.start && !st_q.dend))
        else $error("pulse during burst");
endmodule

// File: tb/gm_hop_timebase_bench.sv
`timescale 1ns/1ps
module gm_hop_timebase_bench;
    localparam int B_FBN  = 144;
    localparam int B_FBG  = 112;
    localparam int B_STOP = 96;
    localparam int B_RES  = 104;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fb_code = 8'd200;
    logic       cyc_start, duty_end, burst_skip;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gm_hop_timebase u_gm_hop_timebase (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fb_code_i    (fb_code),
        .cyc_start_o  (cyc_start),
        .duty_end_o   (duty_end),
        .burst_skip_o (burst_skip)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // ---- requirement formulas ----
    function automatic int g_of(input int fb);
        int f = (fb > B_FBN) ? B_FBN : fb;
        return (f <= B_FBG) ? (B_FBN - B_FBG) : (B_FBN - f);
    endfunction
    function automatic int base_of(input int fb);
        return 100 + (195 * g_of(fb)) / 32;
    endfunction
    function automatic int depth_of(input int fb);
        return 6 + (13 * g_of(fb)) / 32;
    endfunction
    function automatic int div_of(input int fb);
        return 2 + (3 * g_of(fb)) / 32;
    endfunction

    // ---- reference model from the requirements ----
    int m_cnt, m_per, m_duty, m_u, m_hd;
    bit m_up, m_skip, m_start, m_dend;

    always @(posedge clk) begin : model
        int fbv, nu, nhd, per, ns;
        bit nup;
        if (!rst_n) begin
            m_cnt <= 99; m_per <= 100; m_duty <= 89; m_u <= 0; m_hd <= 0;
            m_up <= 1'b1; m_skip <= 1'b0; m_start <= 1'b0; m_dend <= 1'b0;
        end else if (m_cnt == m_per - 1) begin
            fbv = int'(fb_code);
            nu = m_u; nup = m_up; nhd = m_hd + 1;
            if (nhd >= div_of(fbv)) begin
                nhd = 0;
                if (nup) begin
                    if (nu == 4) begin nu = 3; nup = 1'b0; end else nu = nu + 1;
                end else begin
                    if (nu == -4) begin nu = -3; nup = 1'b1; end else nu = nu - 1;
                end
            end
            per = base_of(fbv) + ((nu * depth_of(fbv)) >>> 2);
            ns = m_skip;
            if (fbv < B_STOP) ns = 1;
            else if (fbv > B_RES) ns = 0;
            m_u <= nu; m_up <= nup; m_hd <= nhd;
            m_per <= per; m_duty <= (per * 114) >>> 7;
            m_cnt <= 0; m_skip <= (ns != 0);
            m_start <= (ns == 0); m_dend <= 1'b0;
        end else begin
            m_cnt <= m_cnt + 1;
            m_start <= 1'b0;
            m_dend <= ((m_cnt + 1) == m_duty) && !m_skip;
        end
    end

    // clock-by-clock comparison, counted on event clocks
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cyc_start || m_start || duty_end || m_dend || (burst_skip != m_skip)) begin
                chk(cyc_start == m_start, "R4 start vs model", int'(cyc_start), int'(m_start));
                chk(duty_end == m_dend, "R6 duty end vs model", int'(duty_end), int'(m_dend));
                chk(burst_skip == m_skip, "R7 skip vs model", int'(burst_skip), int'(m_skip));
                chk(!(cyc_start && duty_end), "R9 overlap", 1, 0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 180000 && !done) begin
            failures++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 180000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_reset(input int fb);
        rst_n = 1'b0;
        fb_code = 8'(fb);
        repeat (3) @(negedge clk);
        chk(!cyc_start && !duty_end && !burst_skip, "R1 outputs low in reset",
            int'({cyc_start, duty_end, burst_skip}), 0);
        rst_n = 1'b1;
    endtask

    task automatic meas(output int per, output int dly);
        int k = 0;
        dly = -1;
        do begin
            @(negedge clk);
            k++;
            if (duty_end && dly < 0) dly = k;
        end while (!cyc_start && k < 4000);
        per = k;
    endtask

    task automatic first_period(input int fb, input int exp_per, input int exp_duty, input string tag);
        int p, d;
        do_reset(fb);
        @(negedge clk);
        chk(cyc_start == 1'b1, {tag, " first start"}, int'(cyc_start), 1);
        meas(p, d);
        chk(p == exp_per, {tag, " period"}, p, exp_per);
        chk(d == exp_duty, "R6 duty point", d, exp_duty);
    endtask

    initial begin
        int p, d, k, ns, nd, nsk;
        int seq_n[20] = '{100,101,101,103,103,104,104,106,106,104,
                          104,103,103,101,101,100,100,98,98,97};
        int seq_g[10] = '{295,295,295,295,299,299,299,299,299,304};
        int unsigned seed_v = 32'h5eed_1234;
        void'($urandom(seed_v));

        // R1, R2: reset and clamp above the normal level
        first_period(144, 100, 89, "R1 R2 fb=144");
        first_period(255, 100, 89, "R2 fb=255");
        // R3: slope and floor
        first_period(128, base_of(128), (base_of(128) * 114) >>> 7, "R3 fb=128");
        first_period(120, 246, 219, "R3 fb=120");
        first_period(112, 295, 262, "R3 fb=112");
        first_period(100, 295, 262, "R3 fb=100 floor");

        // R4: normal-mode dither shape
        do_reset(255);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            meas(p, d);
            chk(p == seq_n[i], "R4 normal dither period", p, seq_n[i]);
        end

        // R5: green-mode depth and divider
        do_reset(112);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            meas(p, d);
            chk(p == seq_g[i], "R5 green dither period", p, seq_g[i]);
        end

        // R8: mid-period change
        do_reset(255);
        @(negedge clk);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 30) fb_code = 8'd112;
        end while (!cyc_start && k < 4000);
        chk(k == 100, "R8 running period kept", k, 100);
        meas(p, d);
        chk(p == 295, "R8 new period next", p, 295);

        // R7: burst hysteresis
        do_reset(90);
        @(negedge clk);
        chk(burst_skip && !cyc_start, "R7 burst on first boundary", int'(burst_skip), 1);
        ns = 0; nd = 0;
        repeat (600) begin
            @(negedge clk);
            if (cyc_start) ns++;
            if (duty_end) nd++;
        end
        chk(ns == 0 && nd == 0, "R7 no pulses in burst", ns + nd, 0);
        fb_code = 8'd100;
        nsk = 0;
        repeat (900) begin @(negedge clk); if (!burst_skip) nsk++; end
        chk(nsk == 0, "R7 band holds burst", nsk, 0);
        fb_code = 8'd104;
        nsk = 0;
        repeat (900) begin @(negedge clk); if (!burst_skip) nsk++; end
        chk(nsk == 0, "R7 resume level is exclusive", nsk, 0);
        fb_code = 8'd105;
        k = 0;
        while (burst_skip && k < 1000) begin @(negedge clk); k++; end
        chk(!burst_skip, "R7 burst clears above resume", int'(burst_skip), 0);
        chk(cyc_start, "R7 start with burst exit", int'(cyc_start), 1);
        fb_code = 8'd96;
        nsk = 0;
        repeat (900) begin @(negedge clk); if (burst_skip) nsk++; end
        chk(nsk == 0, "R7 stop level is exclusive", nsk, 0);
        fb_code = 8'd95;
        k = 0;
        while (!burst_skip && k < 1000) begin @(negedge clk); k++; end
        chk(burst_skip, "R7 burst entered below stop", int'(burst_skip), 1);

        // random feedback against the model (R4 R6 R7 R9)
        do_reset(int'($urandom_range(80, 170)));
        repeat (40000) begin
            @(negedge clk);
            if ($urandom_range(0, 149) == 0) begin
                case ($urandom_range(0, 9))
                    0: fb_code = 8'd255;
                    1: fb_code = 8'd0;
                    default: fb_code = 8'($urandom_range(85, 160));
                endcase
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule